// File: doc/BRIEF.md
# Packet Buffer Allocation Command Unit

This block does the buffer bookkeeping for a host-driven Ethernet controller. A small pool of equal-sized packet buffers is tracked as a bitmap, one bit per buffer. Buffers move between three hardware queues as small index values: receive, transmit, and transmit-done. The block never sees packet bytes. The data memory and the MAC sit outside it and use the buffer numbers it hands out.

The host writes through a single register write port with a 2-bit address. Address 0 is the command register, and bits [7:5] of the written byte give the opcode. Address 1 is the packet-number register, address 2 is interrupt acknowledge and address 3 is the interrupt mask. Each command acts directly on the bitmap, the queues and the interrupt status bits. The receive path claims a buffer with `rxReq`, and the transmit side reports a finished frame with `txSent`. Both sideband events are served only in cycles with no register write. The status, the queue heads, the queue counts and the interrupt line are outputs.

Interrupt status bits are: bit 0 receive, bit 1 transmit done, bit 2 transmit queue empty, bit 3 allocation done. The acknowledge register can clear only the bits in the mask 0xD6.

Top module: `pbuf_cmd_unit`

## Requirements
- R1: After reset, `intStatus` is 0x04 (only bit 2 set), `intMask` is 0, `irq` is low, `allocResult` is 0, `allocMap` is all zero and every queue count is 0.
- R2: Only bits [7:5] of a command write select the operation. Opcode 0 changes nothing, and the low five bits never change the operation selected.
- R3: Opcode 1 grants the lowest-numbered free buffer, sets its `allocMap` bit, puts its number in `allocResult` and sets status bit 3. With no free buffer it sets `allocResult` to 0x80, clears bit 3 and leaves the bitmap unchanged.
- R4: `rxReq` in a cycle with no register write and at least one free buffer does three things: it claims the lowest free buffer, appends it to the receive queue and sets status bit 0. `rxTaken` shows this in the same cycle. While a register write is in progress, or when the pool is full, nothing is claimed and `rxTaken` is low.
- R5: Opcode 3 removes the receive queue head and does not release it. After any receive pop, bit 0 stays set if entries remain and is cleared once the queue is empty.
- R6: Opcode 4 first clears the bitmap bit of the receive head, then pops it. On an empty receive queue it leaves the bitmap unchanged.
- R7: Opcode 5 clears the bitmap bit of the buffer held in the packet-number register. That register is written at address 1 and uses its low index bits.
- R8: Opcode 6 appends the packet-number buffer to the transmit queue, and the append is ignored when the queue is full. `txSent` with a non-empty transmit queue and no register write moves the transmit head to the done queue and sets status bit 1. If that empties the transmit queue, it also sets bit 2.
- R9: Opcode 7 empties the transmit and done queues and leaves the bitmap alone.
- R10: Opcode 2 clears the bitmap, all three queues and `allocResult`. It leaves `intStatus` unchanged.
- R11: A write to address 2 clears the status bits set in (value AND 0xD6), so bits 0 and 3 cannot be cleared this way. If bit 1 of the written value is set, the head of the done queue is also removed.
- R12: A write to address 3 loads `intMask`. `irq` is high exactly when some bit of `intStatus` AND `intMask` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 2 | 0 command, 1 packet number, 2 acknowledge, 3 mask |
| regData | input | 8 | Write data |
| rxReq | input | 1 | Receive path asks for a buffer |
| rxTaken | output | 1 | Receive claim accepted this cycle |
| txSent | input | 1 | Transmit side finished the head frame |
| txTaken | output | 1 | Transmit completion accepted this cycle |
| allocMap | output | NUM_BUFS | Allocation bitmap |
| allocResult | output | 8 | Last transmit allocation result, 0x80 on failure |
| intStatus | output | 8 | Interrupt status bits |
| intMask | output | 8 | Interrupt mask |
| irq | output | 1 | Masked interrupt request |
| rxHead | output | IDXW | Receive queue head buffer |
| rxCount | output | CNTW | Receive queue entries |
| txHead | output | IDXW | Transmit queue head buffer |
| txCount | output | CNTW | Transmit queue entries |
| doneHead | output | IDXW | Done queue head buffer |
| doneCount | output | CNTW | Done queue entries |

## Verification
The bench fills the pool completely and then asks for one more buffer. A design that returned a stale index here would report a bogus grant instead of 0x80, or would leave bit 3 set.

It pops the receive queue down through one remaining entry and then to empty. A wrong count compare would clear bit 0 too early or leave it set. It also runs opcode 4 on an empty queue, where a careless release would free whichever buffer the stale head names.

It acknowledges with 0xFF to show that the receive and allocate bits survive while the done queue loses its head. It collides `rxReq` with a register write to show that the claim is refused rather than merged.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int INT_RCV = 0;
  localparam int INT_TX = 1;
  localparam int INT_TXE = 2;
  localparam int INT_ALLOC = 3;
  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] ALLOC_FAIL = 8'h80;
  localparam logic [7:0] INT_RESET = 8'h04;
  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_PKT = 2'd1;
  localparam logic [1:0] ADDR_ACK = 2'd2;
  localparam logic [1:0] ADDR_MASK = 2'd3;

  typedef enum logic [2:0] {
    OP_NOP, OP_ALLOC, OP_RESET, OP_RXPOP,
    OP_RXFREE, OP_REL, OP_TXQ, OP_TXFLUSH
  } opcode_e;

  typedef struct packed {
    logic allocTx;
    logic mmuReset;
    logic rxPop;
    logic rxFree;
    logic relPkt;
    logic txPush;
    logic txFlush;
    logic ackWr;
    logic maskWr;
    logic pktWr;
    logic rxClaim;
    logic txSend;
  } strobe_t;
endpackage

// File: rtl/pbuf_queue.sv
module pbuf_queue #(
  parameter int DEPTH = 4,
  parameter int W = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0] slots [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic doPush, doPop;

  assign doPop = pop && (count != '0);
  assign doPush = push && (count != CW'(DEPTH));
  assign head = slots[rdPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop) rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (doPush && !clear) begin
      slots[wrPtr] <= pushData;
    end
  end
endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
  import pbuf_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regData,
  input  logic       rxReq,
  input  logic       txSent,
  input  logic       anyFree,
  input  logic       txNotEmpty,
  output strobe_t    stb,
  output logic       rxTaken,
  output logic       txTaken
);
  opcode_e op;
  logic cmdWr;

  assign op = opcode_e'(regData[7:5]);
  assign cmdWr = regWrEn && (regAddr == ADDR_CMD);

  always_comb begin
    stb = '0;
    if (cmdWr) begin
      case (op)
        OP_ALLOC:   stb.allocTx = 1'b1;
        OP_RESET:   stb.mmuReset = 1'b1;
        OP_RXPOP:   stb.rxPop = 1'b1;
        OP_RXFREE:  stb.rxFree = 1'b1;
        OP_REL:     stb.relPkt = 1'b1;
        OP_TXQ:     stb.txPush = 1'b1;
        OP_TXFLUSH: stb.txFlush = 1'b1;
        default:    ;
      endcase
    end
    stb.pktWr = regWrEn && (regAddr == ADDR_PKT);
    stb.ackWr = regWrEn && (regAddr == ADDR_ACK);
    stb.maskWr = regWrEn && (regAddr == ADDR_MASK);
    stb.rxClaim = rxReq && !regWrEn && anyFree;
    stb.txSend = txSent && !regWrEn && txNotEmpty;
  end

  assign rxTaken = stb.rxClaim;
  assign txTaken = stb.txSend;
endmodule

// File: rtl/pbuf_datapath.sv
module pbuf_datapath
  import pbuf_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  localparam int IDXW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int CNTW = $clog2(NUM_BUFS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [7:0]          regData,
  output logic                anyFree,
  output logic [NUM_BUFS-1:0] allocMap,
  output logic [7:0]          allocResult,
  output logic [7:0]          intStatus,
  output logic [7:0]          intMask,
  output logic [IDXW-1:0]     rxHead,
  output logic [CNTW-1:0]     rxCount,
  output logic [IDXW-1:0]     txHead,
  output logic [CNTW-1:0]     txCount,
  output logic [IDXW-1:0]     doneHead,
  output logic [CNTW-1:0]     doneCount
);
  logic [IDXW-1:0] freeIdx, pktNum;
  logic [NUM_BUFS-1:0] mapNext;
  logic [7:0] statusNext;
  logic grant, rxAny, txAny;

  assign rxAny = (rxCount != '0);
  assign txAny = (txCount != '0);

  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = NUM_BUFS - 1; i >= 0; i--) begin
      if (!allocMap[i]) begin
        anyFree = 1'b1;
        freeIdx = IDXW'(i);
      end
    end
  end

  assign grant = (stb.allocTx || stb.rxClaim) && anyFree;

  always_comb begin
    mapNext = allocMap;
    if (grant) mapNext[freeIdx] = 1'b1;
    if (stb.rxFree && rxAny) mapNext[rxHead] = 1'b0;
    if (stb.relPkt) mapNext[pktNum] = 1'b0;
    if (stb.mmuReset) mapNext = '0;
  end

  always_comb begin
    statusNext = intStatus;
    if (stb.allocTx) statusNext[INT_ALLOC] = anyFree;
    if (stb.rxClaim) statusNext[INT_RCV] = 1'b1;
    if (stb.rxPop || stb.rxFree) statusNext[INT_RCV] = (rxCount > CNTW'(1));
    if (stb.txSend) begin
      statusNext[INT_TX] = 1'b1;
      if (txCount == CNTW'(1)) statusNext[INT_TXE] = 1'b1;
    end
    if (stb.ackWr) statusNext = statusNext & ~(regData & ACK_CLEARABLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocMap <= '0;
      allocResult <= '0;
      intStatus <= INT_RESET;
      intMask <= '0;
      pktNum <= '0;
    end else begin
      allocMap <= mapNext;
      intStatus <= statusNext;
      if (stb.maskWr) intMask <= regData;
      if (stb.pktWr) pktNum <= regData[IDXW-1:0];
      if (stb.mmuReset) allocResult <= '0;
      else if (stb.allocTx) allocResult <= anyFree ? 8'(freeIdx) : ALLOC_FAIL;
    end
  end

  pbuf_queue #(.DEPTH(NUM_BUFS), .W(IDXW)) i_rxQueue (
    .clk(clk), .rstN(rstN), .clear(stb.mmuReset),
    .push(stb.rxClaim), .pushData(freeIdx),
    .pop(stb.rxPop || stb.rxFree), .head(rxHead), .count(rxCount)
  );

  pbuf_queue #(.DEPTH(NUM_BUFS), .W(IDXW)) i_txQueue (
    .clk(clk), .rstN(rstN), .clear(stb.mmuReset || stb.txFlush),
    .push(stb.txPush), .pushData(pktNum),
    .pop(stb.txSend), .head(txHead), .count(txCount)
  );

  pbuf_queue #(.DEPTH(NUM_BUFS), .W(IDXW)) i_doneQueue (
    .clk(clk), .rstN(rstN), .clear(stb.mmuReset || stb.txFlush),
    .push(stb.txSend && txAny), .pushData(txHead),
    .pop(stb.ackWr && regData[INT_TX]), .head(doneHead), .count(doneCount)
  );
endmodule

// File: rtl/pbuf_cmd_unit.sv
module pbuf_cmd_unit
  import pbuf_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  localparam int IDXW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int CNTW = $clog2(NUM_BUFS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [7:0]          regData,
  input  logic                rxReq,
  output logic                rxTaken,
  input  logic                txSent,
  output logic                txTaken,
  output logic [NUM_BUFS-1:0] allocMap,
  output logic [7:0]          allocResult,
  output logic [7:0]          intStatus,
  output logic [7:0]          intMask,
  output logic                irq,
  output logic [IDXW-1:0]     rxHead,
  output logic [CNTW-1:0]     rxCount,
  output logic [IDXW-1:0]     txHead,
  output logic [CNTW-1:0]     txCount,
  output logic [IDXW-1:0]     doneHead,
  output logic [CNTW-1:0]     doneCount
);
  strobe_t stb;
  logic anyFree;

  pbuf_ctrl i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .rxReq(rxReq), .txSent(txSent), .anyFree(anyFree),
    .txNotEmpty(txCount != '0), .stb(stb),
    .rxTaken(rxTaken), .txTaken(txTaken)
  );

  pbuf_datapath #(.NUM_BUFS(NUM_BUFS)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .regData(regData),
    .anyFree(anyFree), .allocMap(allocMap), .allocResult(allocResult),
    .intStatus(intStatus), .intMask(intMask),
    .rxHead(rxHead), .rxCount(rxCount), .txHead(txHead), .txCount(txCount),
    .doneHead(doneHead), .doneCount(doneCount)
  );

  assign irq = |(intStatus & intMask);
endmodule

// File: rtl/pbuf_cmd_checker.sv
module pbuf_cmd_checker #(
  parameter int NUM_BUFS = 4,
  localparam int IDXW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int CNTW = $clog2(NUM_BUFS + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [1:0]          regAddr,
  input logic [7:0]          regData,
  input logic                rxReq,
  input logic                rxTaken,
  input logic                txSent,
  input logic                txTaken,
  input logic [NUM_BUFS-1:0] allocMap,
  input logic [7:0]          allocResult,
  input logic [7:0]          intStatus,
  input logic [7:0]          intMask,
  input logic                irq,
  input logic [IDXW-1:0]     rxHead,
  input logic [CNTW-1:0]     rxCount,
  input logic [IDXW-1:0]     txHead,
  input logic [CNTW-1:0]     txCount,
  input logic [IDXW-1:0]     doneHead,
  input logic [CNTW-1:0]     doneCount
);
  logic isCmd;
  logic [2:0] op;
  assign isCmd = regWrEn && (regAddr == 2'd0);
  assign op = regData[7:5];

  assert_alloc_fail_R3: assert property (@(posedge clk) disable iff (!rstN)
    isCmd && op == 3'd1 && (&allocMap) |=> allocResult == 8'h80 && !intStatus[3] && (&allocMap));

  assert_alloc_ok_R3: assert property (@(posedge clk) disable iff (!rstN)
    isCmd && op == 3'd1 && !(&allocMap) |=> intStatus[3] && !allocResult[7] && allocMap[allocResult[IDXW-1:0]]);

  assert_rx_claim_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxTaken |=> rxCount == $past(rxCount) + 1'b1 && intStatus[0]);

  assert_rx_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !rxTaken);

  assert_rx_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    isCmd && (op == 3'd3 || op == 3'd4) && rxCount <= 1 |=> rxCount == 0 && !intStatus[0]);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    isCmd && op == 3'd7 |=> txCount == 0 && doneCount == 0 && $stable(allocMap));

  assert_mmu_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    isCmd && op == 3'd2 |=> allocMap == 0 && rxCount == 0 && allocResult == 0 && $stable(intStatus));

  assert_ack_keep_R11: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd2 |=> intStatus[0] == $past(intStatus[0]) && intStatus[3] == $past(intStatus[3]));

  assert_mask_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd3 && regData == 8'h00 |=> !irq);
endmodule

bind pbuf_cmd_unit pbuf_cmd_checker #(.NUM_BUFS(NUM_BUFS)) i_pbuf_cmd_checker (.*);

// File: tb/test_pbuf_cmd_unit.sv
module test_pbuf_cmd_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic rxReq = 1'b0;
  logic txSent = 1'b0;
  logic rxTaken, txTaken, irq;
  logic [3:0] allocMap;
  logic [7:0] allocResult, intStatus, intMask;
  logic [1:0] rxHead, txHead, doneHead;
  logic [2:0] rxCount, txCount, doneCount;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pbuf_cmd_unit #(.NUM_BUFS(4)) i_pbuf_cmd_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regData(regData),
    .rxReq(rxReq), .rxTaken(rxTaken), .txSent(txSent), .txTaken(txTaken),
    .allocMap(allocMap), .allocResult(allocResult), .intStatus(intStatus),
    .intMask(intMask), .irq(irq), .rxHead(rxHead), .rxCount(rxCount),
    .txHead(txHead), .txCount(txCount), .doneHead(doneHead), .doneCount(doneCount)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic claimRx(input logic expTaken, input string req);
    @(negedge clk);
    rxReq = 1'b1;
    #1 check(req, "rxTaken", rxTaken, expTaken);
    @(negedge clk);
    rxReq = 1'b0;
  endtask

  task automatic sendTx(input logic expTaken);
    @(negedge clk);
    txSent = 1'b1;
    #1 check("R8", "txTaken", txTaken, expTaken);
    @(negedge clk);
    txSent = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "intStatus", intStatus, 8'h04);
    check("R1", "intMask", intMask, 0);
    check("R1", "irq", irq, 0);
    check("R1", "allocResult", allocResult, 0);
    check("R1", "allocMap", allocMap, 0);
    check("R1", "counts", {rxCount, txCount, doneCount}, 0);
  endtask

  task automatic testNop();
    wrReg(2'd0, 8'h1F);
    check("R2", "allocMap after nop", allocMap, 0);
    check("R2", "status after nop", intStatus, 8'h04);
    check("R2", "result after nop", allocResult, 0);
  endtask

  task automatic testAlloc();
    wrReg(2'd0, 8'h20);
    check("R3", "first grant", allocResult, 0);
    check("R3", "map after first", allocMap, 4'b0001);
    check("R3", "alloc bit", intStatus, 8'h0C);
    wrReg(2'd0, 8'h20);
    check("R3", "second grant", allocResult, 1);
    wrReg(2'd0, 8'h3F);
    check("R2", "low bits ignored grant", allocResult, 2);
    check("R3", "map after third", allocMap, 4'b0111);
  endtask

  task automatic testRxClaim();
    claimRx(1'b1, "R4");
    check("R4", "map full", allocMap, 4'b1111);
    check("R4", "rxCount", rxCount, 1);
    check("R4", "rxHead", rxHead, 3);
    check("R4", "rcv bit", intStatus[0], 1);
    claimRx(1'b0, "R4");
    check("R4", "rxCount when full", rxCount, 1);
  endtask

  task automatic testAllocFail();
    wrReg(2'd0, 8'h20);
    check("R3", "fail value", allocResult, 8'h80);
    check("R3", "alloc bit cleared", intStatus[3], 0);
    check("R3", "map unchanged", allocMap, 4'b1111);
  endtask

  task automatic testRelease();
    wrReg(2'd1, 8'h01);
    wrReg(2'd0, 8'hA0);
    check("R7", "released buffer 1", allocMap, 4'b1101);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd3; regData = 8'h00; rxReq = 1'b1;
    #1 check("R4", "rxTaken during write", rxTaken, 0);
    @(negedge clk);
    regWrEn = 1'b0; rxReq = 1'b0;
    check("R4", "rxCount after refused", rxCount, 1);
    claimRx(1'b1, "R4");
    check("R4", "rxCount two", rxCount, 2);
    check("R4", "head kept", rxHead, 3);
  endtask

  task automatic testRxPop();
    wrReg(2'd0, 8'h80);
    check("R6", "head released", allocMap, 4'b0111);
    check("R5", "rxCount one left", rxCount, 1);
    check("R5", "rcv stays", intStatus[0], 1);
    check("R5", "new head", rxHead, 1);
    wrReg(2'd0, 8'h60);
    check("R5", "pop keeps map", allocMap, 4'b0111);
    check("R5", "rxCount empty", rxCount, 0);
    check("R5", "rcv cleared", intStatus[0], 0);
    wrReg(2'd0, 8'h80);
    check("R6", "empty pop-release map", allocMap, 4'b0111);
  endtask

  task automatic testTx();
    wrReg(2'd1, 8'h02);
    wrReg(2'd0, 8'hC0);
    check("R8", "txCount one", txCount, 1);
    check("R8", "txHead", txHead, 2);
    wrReg(2'd1, 8'h00);
    wrReg(2'd0, 8'hC0);
    check("R8", "txCount two", txCount, 2);
    wrReg(2'd2, 8'h04);
    check("R11", "txe acked", intStatus, 8'h00);
    sendTx(1'b1);
    check("R8", "txCount after send", txCount, 1);
    check("R8", "doneHead", doneHead, 2);
    check("R8", "tx bit only", intStatus, 8'h02);
    sendTx(1'b1);
    check("R8", "doneCount two", doneCount, 2);
    check("R8", "txe set on empty", intStatus, 8'h06);
    sendTx(1'b0);
  endtask

  task automatic testAck();
    wrReg(2'd2, 8'hFF);
    check("R11", "ackable cleared", intStatus, 8'h00);
    check("R11", "done popped", doneCount, 1);
    check("R11", "done head next", doneHead, 0);
    wrReg(2'd0, 8'h20);
    check("R3", "grant buffer 3", allocResult, 3);
    wrReg(2'd2, 8'hFF);
    check("R11", "alloc bit survives", intStatus, 8'h08);
    check("R11", "done empty", doneCount, 0);
  endtask

  task automatic testMask();
    wrReg(2'd3, 8'h04);
    check("R12", "irq masked off", irq, 0);
    wrReg(2'd3, 8'h08);
    check("R12", "irq on", irq, 1);
    check("R12", "mask value", intMask, 8'h08);
    wrReg(2'd3, 8'h00);
    check("R12", "irq off", irq, 0);
  endtask

  task automatic testFlush();
    wrReg(2'd1, 8'h03);
    wrReg(2'd0, 8'hC0);
    wrReg(2'd0, 8'hC0);
    sendTx(1'b1);
    check("R9", "pre flush", {txCount, doneCount}, {3'd1, 3'd1});
    wrReg(2'd0, 8'hE0);
    check("R9", "queues flushed", {txCount, doneCount}, 0);
    check("R9", "map kept", allocMap, 4'b1111);
  endtask

  task automatic testMmuReset();
    wrReg(2'd0, 8'h40);
    check("R10", "map cleared", allocMap, 0);
    check("R10", "result cleared", allocResult, 0);
    check("R10", "status kept", intStatus, 8'h0A);
    claimRx(1'b1, "R4");
    check("R4", "claims buffer 0", rxHead, 0);
    wrReg(2'd0, 8'h40);
    check("R10", "rx queue cleared", rxCount, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNop();
    testAlloc();
    testRxClaim();
    testAllocFail();
    testRelease();
    testRxPop();
    testTx();
    testAck();
    testMask();
    testFlush();
    testMmuReset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule